// File: doc/BRIEF.md
# Instruction-Sampling Performance Monitor

This block sits beside the fetch stage and picks one fetched instruction out of the stream for detailed measurement. Counter 0 is a wide counter that adds the number of valid fetch slots in each cycle. Software preloads it with the two's-complement distance to the instruction it wants to sample. The valid slot whose count carries counter 0 past its top becomes the sampled instruction. The block records that slot's position and tag. After a fixed delay it opens a measurement window. During the window, counter 1 accumulates either an external event or elapsed cycles.

The window stays open until a completion report names the sampled tag. The report can be a trap, a retire, an abort or a squash. Fetch slots that count after the sampled slot are gathered into a small overcount value. These are the later slots in the overflow cycle and all slots in the cycle after it. Software uses this value to correct the total. In aggregate mode no window is used: both counters simply run, and a counter that wraps can raise an interrupt.

Top module: `smp_pmon`

## Requirements
- R1: After a synchronous active-low reset, every output is zero: counters, window flag, sampled slot and tag, overcount and interrupts.
- R2: Counter 0 may count only when its enable (control bit 0) is set and at least one gate is set: the system gate (bit 2) or the process gate (bit 3). When allowed, it adds the number of set bits in `fetch_vld` each cycle, modulo 2^20. Otherwise it holds its value.
- R3: A write with `wr_addr` 0 loads the control byte from `wr_data[7:0]`. Address 1 loads counter 0 and address 2 loads counter 1, and a counter write takes priority over counting in that cycle. Address 3 changes nothing.
- R4: In sampling mode (control bit 4 set), the profiled slot is the index of the valid bit in `fetch_vld` that brings counter 0 to 2^20. Valid bits are counted from bit 0 upward. The profiled tag is `fetch_tag` plus that index, modulo 2^8. In aggregate mode, overflow never selects an instruction.
- R5: If the overflow happens in fetch cycle F, `win_active` is first high in cycle F+5.
- R6: The overcount is the number of valid slots above the profiled slot in cycle F. It also includes the valid slots of cycle F+1 when counter 0 may count then. It saturates at 7 and is readable from cycle F+2 onward.
- R7: While the window is open, a cycle with any bit of `done_kind` set and `done_tag` equal to the profiled tag is the last active cycle. `win_active` is low in the next cycle. Completions carrying another tag, or arriving before the window opens, have no effect.
- R8: An overflow that occurs while a sample is pending or its window is open is ignored. Slot, tag and overcount keep their values.
- R9: Counter 1 may count only when its enable (bit 1) is set and at least one gate is set. Its source is `ev_in` when bit 5 is 0, or every cycle when bit 5 is 1. In sampling mode it also counts only while `win_active` is high. It wraps modulo 2^20.
- R10: `irq[0]` is high for one cycle after a cycle in which counter 0 overflowed, if bit 6 is set. `irq[1]` is high for one cycle after a cycle in which counter 1 wrapped, if bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 4 | Valid bit per fetch slot this cycle |
| fetch_tag | input | 8 | Tag of slot 0 of this fetch group |
| ev_in | input | 1 | Event pulse for counter 1 |
| done_kind | input | 4 | Completion report: trap, retire, abort, squash |
| done_tag | input | 8 | Tag of the completing instruction |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: control, counter 0, counter 1 |
| wr_data | input | 20 | Write data |
| win_active | output | 1 | Measurement window open |
| prof_slot | output | 2 | Slot index of the sampled instruction |
| prof_tag | output | 8 | Tag of the sampled instruction |
| overcount | output | 3 | Residual count after the sampled slot |
| cnt0_val | output | 20 | Counter 0 |
| cnt1_val | output | 20 | Counter 1 |
| irq | output | 2 | Interrupt requests for counters 1 and 0 |

## Verification
The bench builds the block with its defaults: 20-bit counters, four slots, 8-bit tags, a 3-bit overcount and a lag of five cycles. Counter 0 is preloaded to within 1 to 12 counts of its top, so overflows come every few cycles. Every slot position and every residual value then occurs often. An overflow also falls inside a pending or open window often enough to exercise the ignore rule. Counter 1 is preloaded close to all-ones, so its wrap and interrupt are reached within a few window cycles.

// File: rtl/pmon_pkg.sv
// Shared types for the instruction-sampling performance monitor.
// Assumes the control register is one byte, laid out least significant field last.
package pmon_pkg;

    typedef struct packed {
        logic [1:0] irq_en;     // [7:6] interrupt enables, bit 6 for counter 0
        logic       c1_cycles;  // [5] counter 1 counts cycles instead of ev_in
        logic       sample;     // [4] sampling mode
        logic       proc_gate;  // [3] process counting gate
        logic       sys_gate;   // [2] system counting gate
        logic       c1_en;      // [1] counter 1 enable
        logic       c0_en;      // [0] counter 0 enable
    } pmon_ctrl_t;

    localparam int CTRL_W = $bits(pmon_ctrl_t);

endpackage

// File: rtl/pmon_fetch_cnt.sv
// Counter 0: adds valid fetch slots per cycle and locates the slot that
// carries the count past its top. Assumes SLOTS < 2**NUM_W.
module pmon_fetch_cnt #(
    parameter int CNT_W  = 20,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2,
    parameter int NUM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [SLOTS-1:0]  vld,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf,
    output logic [SLOT_W-1:0] ovf_slot,
    output logic [NUM_W-1:0]  post_cnt,
    output logic [NUM_W-1:0]  grp_cnt
);

    logic [CNT_W:0]     sum;
    logic [NUM_W-1:0]   need;
    logic [NUM_W-1:0]   run;
    logic [NUM_W-1:0]   post;
    logic [SLOT_W-1:0]  slot;

    // Distance to the top, kept modulo 2**NUM_W (only meaningful on overflow).
    assign need = NUM_W'(~cnt[NUM_W-1:0]) + 1'b1;

    // Walk the slots: count valid bits, mark the one that meets the distance.
    always_comb begin
        run  = '0;
        post = '0;
        slot = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (vld[i]) begin
                run = run + 1'b1;
                if (run == need)
                    slot = SLOT_W'(i);
                else if (run > need)
                    post = post + 1'b1;
            end
        end
    end

    assign sum      = {1'b0, cnt} + (CNT_W+1)'(run);
    assign ovf      = count_en & ~wr_en & sum[CNT_W];
    assign ovf_slot = slot;
    assign post_cnt = post;
    assign grp_cnt  = run;

    // Counter register: write wins, otherwise accumulate when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= wr_data;
        else if (count_en)
            cnt <= sum[CNT_W-1:0];
    end

endmodule

// File: rtl/pmon_event_cnt.sv
// Counter 1: single-step event counter with write priority and wrap flag.
// Assumes the caller has already qualified inc with enables and window.
module pmon_event_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = inc & ~wr_en & (&cnt);

    // Counter register: write wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= wr_data;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pmon_window.sv
// Sampling window sequencer: latches the profiled slot and tag on an accepted
// overflow, gathers the residual, opens the window WIN_LAG cycles after the
// overflow cycle and closes it on a matching completion. Assumes WIN_LAG >= 3.
module pmon_window #(
    parameter int TAG_W   = 8,
    parameter int SLOT_W  = 2,
    parameter int NUM_W   = 3,
    parameter int OVC_W   = 3,
    parameter int WIN_LAG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic [SLOT_W-1:0] ovf_slot,
    input  logic [TAG_W-1:0]  ovf_tag,
    input  logic [NUM_W-1:0]  post_cnt,
    input  logic [NUM_W-1:0]  grp_cnt,
    input  logic              count_en,
    input  logic              done_any,
    input  logic [TAG_W-1:0]  done_tag,
    output logic              win,
    output logic [SLOT_W-1:0] slot,
    output logic [TAG_W-1:0]  tag,
    output logic [OVC_W-1:0]  ovc
);

    localparam int PH_W  = $clog2(WIN_LAG);
    localparam int SUM_W = OVC_W + NUM_W;
    localparam logic [SUM_W-1:0] OVC_MAX = SUM_W'((1 << OVC_W) - 1);

    logic [PH_W-1:0]  ph;
    logic             busy;
    logic             close;
    logic [SUM_W-1:0] first_sum;
    logic [SUM_W-1:0] next_sum;

    assign busy      = (ph != '0) | win;
    assign close     = win & done_any & (done_tag == tag);
    assign first_sum = SUM_W'(post_cnt);
    assign next_sum  = SUM_W'(ovc) + SUM_W'(grp_cnt);

    // Saturating narrowing to the overcount width.
    function automatic logic [OVC_W-1:0] sat(input logic [SUM_W-1:0] v);
        return (v > OVC_MAX) ? OVC_W'(OVC_MAX) : OVC_W'(v);
    endfunction

    // Delay phase: 1 in the cycle after overflow, counts up to the window start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (arm_req && !busy)
            ph <= PH_W'(1);
        else if (ph == PH_W'(WIN_LAG - 1))
            ph <= '0;
        else if (ph != '0)
            ph <= ph + 1'b1;
    end

    // Window flag: set at the end of the delay, cleared after a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win <= 1'b0;
        else if (close)
            win <= 1'b0;
        else if (ph == PH_W'(WIN_LAG - 1))
            win <= 1'b1;
    end

    // Profiled identity: captured once per accepted overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            tag  <= '0;
        end else if (arm_req && !busy) begin
            slot <= ovf_slot;
            tag  <= ovf_tag;
        end
    end

    // Residual: later slots of the overflow cycle, then the following cycle's slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovc <= '0;
        else if (arm_req && !busy)
            ovc <= sat(first_sum);
        else if (ph == PH_W'(1) && count_en)
            ovc <= sat(next_sum);
    end

endmodule

// File: rtl/smp_pmon.sv
// Top of the instruction-sampling performance monitor: control register,
// counter gating, the two counters, the window sequencer and interrupts.
// Assumes fetch_tag names slot 0 and later slots carry consecutive tags.
module smp_pmon
    import pmon_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int SLOTS   = 4,
    parameter int TAG_W   = 8,
    parameter int OVC_W   = 3,
    parameter int WIN_LAG = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SLOTS-1:0]                     fetch_vld,
    input  logic [TAG_W-1:0]                     fetch_tag,
    input  logic                                 ev_in,
    input  logic [3:0]                           done_kind,
    input  logic [TAG_W-1:0]                     done_tag,
    input  logic                                 wr_en,
    input  logic [1:0]                           wr_addr,
    input  logic [CNT_W-1:0]                     wr_data,
    output logic                                 win_active,
    output logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] prof_slot,
    output logic [TAG_W-1:0]                     prof_tag,
    output logic [OVC_W-1:0]                     overcount,
    output logic [CNT_W-1:0]                     cnt0_val,
    output logic [CNT_W-1:0]                     cnt1_val,
    output logic [1:0]                           irq
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int NUM_W  = $clog2(SLOTS + 1);

    pmon_ctrl_t        ctrl_q;
    logic              gate_any;
    logic              en0;
    logic              en1;
    logic              wr_ctrl;
    logic              wr_c0;
    logic              wr_c1;
    logic              ovf0;
    logic              wrap1;
    logic              inc1;
    logic [SLOT_W-1:0] ovf_slot;
    logic [NUM_W-1:0]  post_cnt;
    logic [NUM_W-1:0]  grp_cnt;
    logic [1:0]        irq_q;

    assign wr_ctrl  = wr_en & (wr_addr == 2'd0);
    assign wr_c0    = wr_en & (wr_addr == 2'd1);
    assign wr_c1    = wr_en & (wr_addr == 2'd2);
    assign gate_any = ctrl_q.sys_gate | ctrl_q.proc_gate;
    assign en0      = ctrl_q.c0_en & gate_any;
    assign en1      = ctrl_q.c1_en & gate_any;
    assign inc1     = en1 & (ctrl_q.c1_cycles | ev_in) & (~ctrl_q.sample | win_active);

    // Control register: loaded from the low byte on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= pmon_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    pmon_fetch_cnt #(
        .CNT_W (CNT_W),
        .SLOTS (SLOTS),
        .SLOT_W(SLOT_W),
        .NUM_W (NUM_W)
    ) u_c0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(en0),
        .vld     (fetch_vld),
        .wr_en   (wr_c0),
        .wr_data (wr_data),
        .cnt     (cnt0_val),
        .ovf     (ovf0),
        .ovf_slot(ovf_slot),
        .post_cnt(post_cnt),
        .grp_cnt (grp_cnt)
    );

    pmon_event_cnt #(
        .CNT_W(CNT_W)
    ) u_c1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (inc1),
        .wr_en  (wr_c1),
        .wr_data(wr_data),
        .cnt    (cnt1_val),
        .wrap   (wrap1)
    );

    pmon_window #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .NUM_W  (NUM_W),
        .OVC_W  (OVC_W),
        .WIN_LAG(WIN_LAG)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (ovf0 & ctrl_q.sample),
        .ovf_slot(ovf_slot),
        .ovf_tag (fetch_tag + TAG_W'(ovf_slot)),
        .post_cnt(post_cnt),
        .grp_cnt (grp_cnt),
        .count_en(en0),
        .done_any(|done_kind),
        .done_tag(done_tag),
        .win     (win_active),
        .slot    (prof_slot),
        .tag     (prof_tag),
        .ovc     (overcount)
    );

    // Interrupt pulses: one cycle after an enabled counter wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= {wrap1 & ctrl_q.irq_en[1], ovf0 & ctrl_q.irq_en[0]};
    end

    assign irq = irq_q;

endmodule

// File: rtl/pmon_chk.sv
// Property checker for smp_pmon, bound into every instance.
// Assumes it sees the top's ports plus the registered control byte.
module pmon_chk
    import pmon_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAG_W = 8,
    parameter int OVC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       done_kind,
    input logic [TAG_W-1:0] done_tag,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             win_active,
    input logic [TAG_W-1:0] prof_tag,
    input logic [OVC_W-1:0] overcount,
    input logic [CNT_W-1:0] cnt0_val,
    input logic [CNT_W-1:0] cnt1_val,
    input logic [1:0]       irq,
    input pmon_ctrl_t       ctrl_q
);

    logic hit;
    assign hit = (|done_kind) && (done_tag == prof_tag);

    // R7: a matching completion ends the window next cycle
    a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
        win_active && hit |=> !win_active);

    // R7: nothing else closes an open window
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        win_active && !hit |=> win_active);

    // R8: profiled tag and overcount stay fixed while the window is open
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> $stable(prof_tag) && $stable(overcount));

    // R9: in sampling mode counter 1 holds outside the window
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.sample && !win_active && !(wr_en && wr_addr == 2'd2) |=> $stable(cnt1_val));

    // R2: counter 0 holds when not allowed to count and not written
    a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.c0_en && (ctrl_q.sys_gate || ctrl_q.proc_gate)) && !(wr_en && wr_addr == 2'd1)
        |=> $stable(cnt0_val));

    // R10: a counter 0 interrupt follows a wrap of counter 0
    a_r10_irq0: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> ($past(cnt0_val) > cnt0_val) || $past(wr_en));

endmodule

bind smp_pmon pmon_chk #(
    .CNT_W(CNT_W),
    .TAG_W(TAG_W),
    .OVC_W(OVC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_kind (done_kind),
    .done_tag  (done_tag),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .win_active(win_active),
    .prof_tag  (prof_tag),
    .overcount (overcount),
    .cnt0_val  (cnt0_val),
    .cnt1_val  (cnt1_val),
    .irq       (irq),
    .ctrl_q    (ctrl_q)
);

// File: tb/sim_smp_pmon.sv
`timescale 1ns/1ps
module sim_smp_pmon;

    localparam int TOP = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fetch_vld = '0;
    logic [7:0]  fetch_tag = '0;
    logic        ev_in = 1'b0;
    logic [3:0]  done_kind = '0;
    logic [7:0]  done_tag = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic        win_active;
    logic [1:0]  prof_slot;
    logic [7:0]  prof_tag;
    logic [2:0]  overcount;
    logic [19:0] cnt0_val;
    logic [19:0] cnt1_val;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // model state
    int m_c0, m_c1, m_slot, m_tag, m_ovc, m_F, cyc;
    bit m_win, m_armed;
    bit [1:0] m_irq;
    bit [7:0] m_ctrl;

    always #4 clk = ~clk;

    smp_pmon u0 (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_tag(fetch_tag),
        .ev_in(ev_in), .done_kind(done_kind), .done_tag(done_tag), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .win_active(win_active),
        .prof_slot(prof_slot), .prof_tag(prof_tag), .overcount(overcount),
        .cnt0_val(cnt0_val), .cnt1_val(cnt1_val), .irq(irq)
    );

    function automatic int ones4(input logic [3:0] v);
        int n = 0;
        for (int i = 0; i < 4; i++) n += v[i] ? 1 : 0;
        return n;
    endfunction

    // index of the k-th valid slot, counting from bit 0
    function automatic int kth_slot(input logic [3:0] v, input int k);
        int seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (v[i]) begin
                seen++;
                if (seen == k) return i;
            end
        end
        return 0;
    endfunction

    // Reference model, advanced once per clock edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_c0 = 0; m_c1 = 0; m_slot = 0; m_tag = 0; m_ovc = 0; m_F = -100;
            m_win = 0; m_armed = 0; m_irq = 0; m_ctrl = 0; cyc = 0;
        end else begin
            bit gate, g0, g1, ovf, inc, wr1, n_win, n_armed;
            int n, nc0, nc1;
            gate = m_ctrl[2] | m_ctrl[3];
            g0 = m_ctrl[0] & gate;
            g1 = m_ctrl[1] & gate;
            n = ones4(fetch_vld);
            ovf = 0;
            nc0 = m_c0;
            if (wr_en && wr_addr == 2'd1) nc0 = int'(wr_data);
            else if (g0) begin
                ovf = (m_c0 + n) >= TOP;
                nc0 = (m_c0 + n) % TOP;
            end
            n_win = m_win; n_armed = m_armed;
            if (m_armed && cyc == m_F + 1 && g0)
                m_ovc = (m_ovc + n > 7) ? 7 : m_ovc + n;
            if (m_win && done_kind != 0 && int'(done_tag) == m_tag) begin
                n_win = 0; n_armed = 0;
            end else if (m_armed && !m_win && cyc == m_F + 4) begin
                n_win = 1;
            end
            if (ovf && m_ctrl[4] && !m_armed) begin
                int k;
                k = TOP - m_c0;
                m_slot = kth_slot(fetch_vld, k);
                m_tag = (int'(fetch_tag) + m_slot) % 256;
                m_ovc = n - k;
                m_F = cyc;
                n_armed = 1;
            end
            wr1 = wr_en && wr_addr == 2'd2;
            inc = g1 && (m_ctrl[5] || ev_in) && (!m_ctrl[4] || m_win);
            nc1 = m_c1;
            if (wr1) nc1 = int'(wr_data);
            else if (inc) nc1 = (m_c1 + 1) % TOP;
            m_irq = {inc && !wr1 && m_c1 == TOP - 1 && m_ctrl[7], ovf && m_ctrl[6]};
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[7:0];
            m_c0 = nc0; m_c1 = nc1; m_win = n_win; m_armed = n_armed;
            cyc++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_all();
        chk("R2 counter0", int'(cnt0_val), m_c0);
        chk("R9 counter1", int'(cnt1_val), m_c1);
        chk("R5 R7 window", int'(win_active), int'(m_win));
        chk("R4 R8 slot", int'(prof_slot), m_slot);
        chk("R4 R8 tag", int'(prof_tag), m_tag);
        chk("R6 overcount", int'(overcount), m_ovc);
        chk("R10 irq", int'(irq), int'(m_irq));
    endtask

    task automatic idle_inputs();
        wr_en = 0; done_kind = 0; ev_in = 0; fetch_vld = 0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [19:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    initial begin : main
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 cnt0", int'(cnt0_val), 0);
        chk("R1 cnt1", int'(cnt1_val), 0);
        chk("R1 win", int'(win_active), 0);
        chk("R1 ovc", int'(overcount), 0);
        chk("R1 tag", int'(prof_tag), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1;

        // R2: counter 0 gated off with no control written
        fetch_vld = 4'hF;
        @(negedge clk);
        chk("R2 gated", int'(cnt0_val), 0);
        // control: c0, c1, sys gate, sampling, both interrupts
        idle_inputs(); do_write(2'd0, 20'h000D7);
        @(negedge clk); check_all();
        // R3: write wins over counting
        idle_inputs(); fetch_vld = 4'hF; do_write(2'd1, 20'd5);
        @(negedge clk);
        chk("R3 write wins", int'(cnt0_val), 5);
        // R3: address 3 changes nothing
        do_write(2'd3, 20'hFFFFF);
        @(negedge clk);
        chk("R3 addr3 c0", int'(cnt0_val), 9);
        chk("R3 addr3 c1", int'(cnt1_val), 0);
        // R4 R5 R6: directed overflow on slot 2 of 1111 with residual 1+3
        idle_inputs(); do_write(2'd1, 20'(TOP - 3));
        @(negedge clk); check_all();
        idle_inputs(); fetch_vld = 4'hF; fetch_tag = 8'd40;
        @(negedge clk); check_all();
        fetch_vld = 4'b1011;
        @(negedge clk); check_all();
        chk("R4 slot", int'(prof_slot), 2);
        chk("R4 tag", int'(prof_tag), 42);
        idle_inputs();
        @(negedge clk); check_all();
        chk("R6 residual", int'(overcount), 4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); check_all();
        end
        chk("R5 window open", int'(win_active), 1);
        // R7: a non-matching completion has no effect, a matching one closes
        done_kind = 4'b0010; done_tag = 8'd7;
        @(negedge clk); check_all();
        chk("R7 other tag", int'(win_active), 1);
        done_kind = 4'b1000; done_tag = 8'd42;
        @(negedge clk); check_all();
        chk("R7 closed", int'(win_active), 0);
        idle_inputs();

        // constrained random phase
        for (int c = 0; c < 6000; c++) begin
            int r;
            @(negedge clk);
            check_all();
            idle_inputs();
            fetch_vld = 4'($urandom);
            fetch_tag = 8'($urandom);
            ev_in = 1'($urandom);
            r = $urandom_range(0, 99);
            if (r < 6) do_write(2'd1, 20'(TOP - $urandom_range(1, 12)));
            else if (r < 8) do_write(2'd2, 20'(TOP - $urandom_range(1, 4)));
            else if (r < 9) do_write(2'd0, {12'd0, 8'($urandom) | 8'h01});
            else if (r < 10) do_write(2'd3, 20'($urandom));
            if ($urandom_range(0, 5) == 0) begin
                done_kind = 4'($urandom_range(1, 15));
                done_tag = ($urandom_range(0, 1) == 0) ? 8'(m_tag) : 8'($urandom);
            end
        end
        @(negedge clk); check_all();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : seed
        process::self().srandom(32'd1234);
    end

endmodule